// File: doc/BRIEF.md
# Interrupt Line Conditioner

This block sits between one legacy interrupt or data input pin and the serial interrupt agent that reports that line to a host. It brings the asynchronous input into the clock domain through a flop chain. A symmetric filter then discards low-going and high-going pulses that are shorter than a programmed number of clocks. A low level that survives the filter is latched, and the reported level stays low until the agent signals that a low has been carried to the host in the line's slot.

Alongside the filtered path there is a fast path. It emits a one-cycle strobe whenever the synchronized input changes level, before any filtering. The agent can use this strobe to request a new serial cycle at once rather than waiting for the filter. The strobe can therefore fire for a pulse that the filter later rejects, which costs only a serial cycle that reports no change. Slot timing and the serial bus itself are handled elsewhere.

Top module: `irq_line_conditioner`

## Requirements
- R1: During and after reset, `irq_level` is 1 (idle high) and `change_strobe` is 0.
- R2: A low-going pulse on `irq_raw` lasting fewer than FILT_CLKS clocks (default 3) never drives `irq_level` to 0.
- R3: While the filtered level is low and no low is pending, a high-going pulse on `irq_raw` lasting fewer than FILT_CLKS clocks does not raise `irq_level`.
- R4: When `irq_raw` goes low and stays low for at least FILT_CLKS clocks, `irq_level` becomes 0 after the (FILT_CLKS+2)-th rising edge following the change, and not earlier.
- R5: After a filtered low, `irq_level` stays 0 while `low_sent_ack` is not asserted, even after `irq_raw` has returned high for longer than the filter time.
- R6: When `low_sent_ack` is 1 at a rising edge while the filtered level is already high, `irq_level` returns to 1 directly after that edge.
- R7: When `low_sent_ack` arrives while the filtered level is still low, the pending low is cleared, and `irq_level` then rises after the (FILT_CLKS+2)-th edge following the raw rise.
- R8: Every level change of `irq_raw` that lasts at least one clock, including a change that the filter rejects, produces `change_strobe` = 1 for the cycle after the 3rd rising edge that follows it. A change that is not followed by another within one clock gives a strobe of exactly one cycle.
- R9: `low_sent_ack` asserted with no pending low leaves `irq_level` at 1 and `change_strobe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 1 | Asynchronous interrupt or data input, idle high, active low |
| low_sent_ack | input | 1 | Agent confirms that the low level was sent in the line's slot |
| irq_level | output | 1 | Filtered level, held low until acknowledged |
| change_strobe | output | 1 | One-cycle pulse on any synchronized input change, unfiltered |

## Verification
Each result has a fixed delay from the input change. The strobe is due after edge 3. A filtered fall or rise reaches `irq_level` after edge FILT_CLKS+2. An acknowledge releases a held low after the same edge that samples it. The bench drives inputs and samples outputs only at falling edges, and counts rising edges from each input change. Each result is checked in the cycle it is due, and for R4 also in the cycle just before. For the glitch cases the bench watches `irq_level` at every falling edge over a window that is longer than the filter's complete response.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Level the line rests at when no interrupt is asserted.
    localparam logic IDLE_LEVEL = 1'b1;

    // Default depth of the input synchronizer.
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // State exported by the glitch filter.
    typedef struct packed {
        logic level;   // accepted level
        logic fell;    // one-cycle marker: the accepted level just went low
    } irqc_filt_t;

    // Counter width for a filter that must count 0 .. n-1.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned STAGES  = irqc_pkg::SYNC_STAGES_DEF,
    parameter logic        RST_VAL = irqc_pkg::IDLE_LEVEL
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter logic RST_VAL = irqc_pkg::IDLE_LEVEL
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic strobe
);
    logic last_q;
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= RST_VAL;
            strobe_q <= 1'b0;
        end else begin
            last_q   <= lvl;
            strobe_q <= lvl ^ last_q;
        end
    end

    assign strobe = strobe_q;
endmodule

// File: rtl/irqc_filter.sv
module irqc_filter
    import irqc_pkg::*;
#(
    parameter int unsigned FILT_CLKS = 3,
    localparam int unsigned CW       = cnt_w(FILT_CLKS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    output irqc_filt_t stat
);
    logic [CW-1:0] run_q;
    logic          acc_q;
    logic          fell_q;
    logic          differs;
    logic          commit;

    assign differs = (lvl != acc_q);
    assign commit  = differs && (run_q == CW'(FILT_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            acc_q  <= IDLE_LEVEL;
            fell_q <= 1'b0;
        end else begin
            fell_q <= commit && !lvl;
            if (!differs || commit) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
            if (commit) acc_q <= lvl;
        end
    end

    assign stat.level = acc_q;
    assign stat.fell  = fell_q;
endmodule

// File: rtl/irqc_hold.sv
module irqc_hold
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irqc_filt_t stat,
    input  logic       ack,
    output logic       level,
    output logic       pending
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (stat.fell) pend_q <= 1'b1;
        else if (ack)       pend_q <= 1'b0;
    end

    assign level   = stat.level & ~pend_q;
    assign pending = pend_q;
endmodule

// File: rtl/irq_line_conditioner.sv
module irq_line_conditioner
    import irqc_pkg::*;
#(
    parameter int unsigned FILT_CLKS   = 3,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_raw,
    input  logic low_sent_ack,
    output logic irq_level,
    output logic change_strobe
);
    logic       sync_q;
    irqc_filt_t filt_st;
    logic       pend_q;

    irqc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
        .clk(clk), .rst(rst), .d(irq_raw), .q(sync_q)
    );

    irqc_edge #(.RST_VAL(IDLE_LEVEL)) u_edge (
        .clk(clk), .rst(rst), .lvl(sync_q), .strobe(change_strobe)
    );

    irqc_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
        .clk(clk), .rst(rst), .lvl(sync_q), .stat(filt_st)
    );

    irqc_hold u_hold (
        .clk(clk), .rst(rst), .stat(filt_st), .ack(low_sent_ack),
        .level(irq_level), .pending(pend_q)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic clk,
    input logic rst,
    input logic low_sent_ack,
    input logic irq_level,
    input logic change_strobe,
    input logic sync_lvl,
    input logic filt_lvl,
    input logic pend
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: outputs idle right after reset releases
    always @(posedge clk) begin
        if (!rst && rst_q) begin
            p_reset_idle_r1: assert (irq_level && !change_strobe)
                else $error("p_reset_idle_r1");
        end
    end

    // R8: a synchronized change is followed by a strobe
    p_strobe_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl != $past(sync_lvl)) |=> change_strobe);

    // R5: a pending low without acknowledge keeps the output low
    p_level_held_r5: assert property (@(posedge clk) disable iff (rst)
        (pend && !low_sent_ack) |=> !irq_level);

    // R2, R3: the accepted level only moves to a value held for two cycles or more
    p_filter_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (filt_lvl != $past(filt_lvl)) |->
            ($past(sync_lvl) == filt_lvl) && ($past(sync_lvl, 2) == filt_lvl));

    // R6: acknowledge with the filtered level high releases on the next clock
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (low_sent_ack && pend && filt_lvl && sync_lvl) |=> irq_level);
endmodule

bind irq_line_conditioner irqc_checker u_chk (
    .clk(clk), .rst(rst), .low_sent_ack(low_sent_ack),
    .irq_level(irq_level), .change_strobe(change_strobe),
    .sync_lvl(sync_q), .filt_lvl(filt_st.level), .pend(pend_q)
);

// File: tb/tb_irq_line_conditioner.sv
module tb_irq_line_conditioner;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_raw = 1'b1;
    logic low_sent_ack = 1'b0;
    logic irq_level;
    logic change_strobe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_line_conditioner #(.FILT_CLKS(N)) dut (
        .clk(clk), .rst(rst), .irq_raw(irq_raw), .low_sent_ack(low_sent_ack),
        .irq_level(irq_level), .change_strobe(change_strobe)
    );

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Advance k falling edges: from between edges e and e+1 to between e+k and e+k+1.
    task automatic adv(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic settle();
        irq_raw = 1'b1;
        adv(2 * N + 6);
        low_sent_ack = 1'b1;
        adv(1);
        low_sent_ack = 1'b0;
        adv(4);
    endtask

    task automatic t_reset();
        adv(1);
        chk(irq_level === 1'b1, "R1 level in reset", irq_level, 1'b1);
        chk(change_strobe === 1'b0, "R1 strobe in reset", change_strobe, 1'b0);
        rst = 1'b0;
        adv(1);
        chk(irq_level === 1'b1, "R1 level after reset", irq_level, 1'b1);
        chk(change_strobe === 1'b0, "R1 strobe after reset", change_strobe, 1'b0);
    endtask

    task automatic t_low_glitch(input int w);
        bit stayed = 1'b1;
        logic seen = 1'b1;
        irq_raw = 1'b0;
        adv(w);
        irq_raw = 1'b1;
        adv(3 - w);
        chk(change_strobe === 1'b1, "R8 strobe on rejected glitch", change_strobe, 1'b1);
        for (int i = 0; i < N + 10; i++) begin
            if (irq_level !== 1'b1) begin stayed = 1'b0; seen = irq_level; end
            adv(1);
        end
        chk(stayed, "R2 short low ignored", seen, 1'b1);
        settle();
    endtask

    task automatic t_long_low();
        irq_raw = 1'b0;
        adv(2);
        chk(change_strobe === 1'b0, "R8 strobe not before edge 3", change_strobe, 1'b0);
        adv(1);
        chk(change_strobe === 1'b1, "R8 strobe after edge 3", change_strobe, 1'b1);
        adv(1);
        chk(change_strobe === 1'b0, "R8 strobe single cycle", change_strobe, 1'b0);
        adv(N - 3);
        chk(irq_level === 1'b1, "R4 level not early", irq_level, 1'b1);
        adv(1);
        chk(irq_level === 1'b0, "R4 level low on time", irq_level, 1'b0);
        irq_raw = 1'b1;
        adv(2 * N + 6);
        chk(irq_level === 1'b0, "R5 low held without ack", irq_level, 1'b0);
        low_sent_ack = 1'b1;
        adv(1);
        low_sent_ack = 1'b0;
        chk(irq_level === 1'b1, "R6 release on ack", irq_level, 1'b1);
        settle();
    endtask

    task automatic t_high_glitch();
        bit stayed = 1'b1;
        logic seen = 1'b0;
        irq_raw = 1'b0;
        adv(N + 4);
        low_sent_ack = 1'b1;
        adv(1);
        low_sent_ack = 1'b0;
        chk(irq_level === 1'b0, "R7 ack while low keeps low", irq_level, 1'b0);
        irq_raw = 1'b1;
        adv(N - 1);
        irq_raw = 1'b0;
        for (int i = 0; i < N + 10; i++) begin
            if (irq_level !== 1'b0) begin stayed = 1'b0; seen = irq_level; end
            adv(1);
        end
        chk(stayed, "R3 short high ignored", seen, 1'b0);
        irq_raw = 1'b1;
        adv(N + 1);
        chk(irq_level === 1'b0, "R7 rise not early", irq_level, 1'b0);
        adv(1);
        chk(irq_level === 1'b1, "R7 rise after filter", irq_level, 1'b1);
        settle();
    endtask

    task automatic t_idle_ack();
        bit ok = 1'b1;
        low_sent_ack = 1'b1;
        for (int i = 0; i < 3; i++) begin
            adv(1);
            if (irq_level !== 1'b1 || change_strobe !== 1'b0) ok = 1'b0;
        end
        low_sent_ack = 1'b0;
        adv(1);
        chk(ok && irq_level === 1'b1, "R9 idle ack no effect", irq_level, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        settle();
        t_low_glitch(1);
        t_low_glitch(2);
        t_long_low();
        t_high_glitch();
        t_idle_ack();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule